// File: doc/BRIEF.md
# Fixed-Point Load Execution Unit

This unit carries out the integer load operations of a 64-bit register machine. A decoded request arrives with an access width, flags that choose sign extension, byte reversal and address update, an addressing mode, the destination and base register numbers, and the operand values the register file already read: the base, the index and a 16-bit immediate. The unit adds these into an effective address and issues exactly one read on a plain request/response memory port. When the data comes back, it shapes the bytes into the 64-bit destination value.

The result goes out on two writeback ports that share a single done strobe. One port writes the destination register. The other writes the effective address back into the base register when an update form asks for it. An update form that names register 0 as its base, or that names the same register for base and destination, is illegal. The unit rejects it: it sets an invalid-form flag, performs no memory read and writes nothing back.

Top module: `fxld_unit`

## Requirements
- R1: `req_ready` is high only while the unit is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. Any request offered while the unit is busy has no effect on the operation in flight.
- R2: With `req_mode` = 0 (displacement), the effective address is the base term plus the 16-bit `req_imm`, sign-extended to 64 bits.
- R3: With `req_mode` = 1 (scaled displacement), the offset is formed from `req_imm[13:0]` with two zero bits appended below it, and that 16-bit value is sign-extended. `req_imm[15:14]` is ignored.
- R4: With `req_mode` = 2 or 3 (indexed), the effective address is the base term plus `req_index`.
- R5: The base term is zero whenever `req_ra` is 0, whatever the value on `req_base`. Otherwise it is `req_base`.
- R6: A legal request produces exactly one cycle of `mem_req_valid`, carrying the effective address and the size code (0 byte, 1 halfword, 2 word, 3 doubleword). The response holds the 2^size bytes right-aligned in `mem_rsp_data`, with the byte at the lowest address in the most significant of those positions.
- R7: Without byte reversal or sign extension, the loaded value sits in the low bits of `rt_data` and every bit above it is zero.
- R8: With `req_sext` set, halfword and word loads are sign-extended to 64 bits. The flag has no effect on byte or doubleword loads.
- R9: With `req_brev` set, the byte order of the loaded value is reversed, so the lowest-address byte becomes the least significant. The result is zero-extended and `req_sext` is ignored.
- R10: An update request with `req_ra` nonzero and different from `req_rt` raises `ra_we` together with `rt_we`. `ra_idx` then equals `req_ra` and `ra_data` equals the effective address.
- R11: An update request with `req_ra` = 0 or `req_ra` = `req_rt` raises `bad_form` with `done`. It issues no memory read and raises neither write enable.
- R12: `done` is a one-cycle pulse, and the result, indices and enables are valid in that cycle. `ra_we` is never raised for a request without the update flag.
- R13: After reset, `req_ready` is high and `done`, `mem_req_valid`, `rt_we`, `ra_we` and `bad_form` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Load request offered |
| req_ready | output | 1 | Unit idle; request can be taken |
| req_size | input | 2 | Access width code |
| req_sext | input | 1 | Sign-extend halfword/word result |
| req_brev | input | 1 | Byte-reversed load |
| req_upd | input | 1 | Update form: write EA back to base register |
| req_mode | input | 2 | 0 displacement, 1 scaled displacement, 2/3 indexed |
| req_rt | input | 5 | Destination register number |
| req_ra | input | 5 | Base register number (0 means zero base) |
| req_base | input | 64 | Base register contents |
| req_index | input | 64 | Index register contents |
| req_imm | input | 16 | Immediate field |
| mem_req_valid | output | 1 | Memory read request, one cycle |
| mem_req_addr | output | 64 | Read address |
| mem_req_size | output | 2 | Read width code |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Read data, right-aligned, lowest address most significant |
| done | output | 1 | Operation complete, one cycle |
| bad_form | output | 1 | Illegal update form rejected |
| rt_we | output | 1 | Destination writeback enable |
| rt_idx | output | 5 | Destination register number |
| rt_data | output | 64 | Formatted load result |
| ra_we | output | 1 | Base-register update enable |
| ra_idx | output | 5 | Base register number |
| ra_data | output | 64 | Effective address for the update |

## Verification
The properties assume that the memory side answers only after a read has been issued and returns at most one response for each read. They also assume that nothing drives `mem_rsp_valid` while no read is outstanding. The bench memory model meets this by construction: it raises `mem_rsp_valid` for exactly one cycle, and only in the cycle after it sees `mem_req_valid`. The bench drives every request field from a negative edge and keeps it stable across the accepting edge. The one test that offers a request while the unit is busy checks R1 at the ports and does not rely on an assumed stimulus.

// File: rtl/fxld_pkg.sv
package fxld_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_DBL  = 2'd3
   } fx_size_e;

   typedef enum logic [1:0] {
      AM_DISP   = 2'd0,
      AM_DSCALE = 2'd1,
      AM_INDEX  = 2'd2,
      AM_INDEX2 = 2'd3
   } fx_amode_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ISSUE = 2'd1,
      ST_WAIT  = 2'd2,
      ST_DONE  = 2'd3
   } fx_state_e;

endpackage

// File: rtl/fxld_agen.sv
module fxld_agen #(
   parameter int XLEN     = 64,
   parameter int RIDX_W   = 5,
   parameter int IMM_W    = 16,
   parameter int DS_W     = 14,
   parameter int DS_SHIFT = 2
) (
   input  logic [1:0]        mode,
   input  logic [RIDX_W-1:0] ra,
   input  logic [XLEN-1:0]   base,
   input  logic [XLEN-1:0]   index,
   input  logic [IMM_W-1:0]  imm,
   output logic [XLEN-1:0]   ea
);
   import fxld_pkg::*;

   localparam int D_EXT  = XLEN - IMM_W;
   localparam int DS_EXT = XLEN - DS_W - DS_SHIFT;

   generate
      if (IMM_W > XLEN || DS_W > IMM_W || DS_W + DS_SHIFT > XLEN) begin : g_bad_cfg
         $error("fxld_agen: immediate widths do not fit the register width");
      end
   endgenerate

   logic [XLEN-1:0] base_term;
   logic [XLEN-1:0] disp_off;
   logic [XLEN-1:0] ds_off;
   logic [XLEN-1:0] offset;

   assign base_term = (ra == '0) ? '0 : base;
   assign disp_off  = {{D_EXT{imm[IMM_W-1]}}, imm};
   assign ds_off    = {{DS_EXT{imm[DS_W-1]}}, imm[DS_W-1:0], {DS_SHIFT{1'b0}}};

   always_comb begin
      case (fx_amode_e'(mode))
         AM_DISP:   offset = disp_off;
         AM_DSCALE: offset = ds_off;
         default:   offset = index;
      endcase
   end

   assign ea = base_term + offset;

endmodule

// File: rtl/fxld_fmt.sv
module fxld_fmt #(
   parameter int XLEN = 64
) (
   input  logic [1:0]      size,
   input  logic            sext,
   input  logic            brev,
   input  logic [XLEN-1:0] raw,
   output logic [XLEN-1:0] result
);
   import fxld_pkg::*;

   localparam int NB     = XLEN / 8;
   localparam int NSIZES = 4;

   generate
      if (XLEN < 64 || (XLEN % 8) != 0) begin : g_bad_cfg
         $error("fxld_fmt: XLEN must be a multiple of 8 and at least 64");
      end
   endgenerate

   logic [NSIZES-1:0][XLEN-1:0] nat_sz;
   logic [NSIZES-1:0][XLEN-1:0] sx_sz;
   logic [NSIZES-1:0][XLEN-1:0] rev_sz;

   generate
      for (genvar s = 0; s < NSIZES; s++) begin : g_size
         localparam int NBY = 1 << s;
         localparam int W   = 8 * NBY;
         assign nat_sz[s] = XLEN'(raw[W-1:0]);
         assign sx_sz[s]  = XLEN'($signed(raw[W-1:0]));
         for (genvar g = 0; g < NB; g++) begin : g_lane
            if (g < NBY) begin : g_in
               assign rev_sz[s][8*g +: 8] = raw[8*(NBY-1-g) +: 8];
            end else begin : g_out
               assign rev_sz[s][8*g +: 8] = 8'h00;
            end
         end
      end
   endgenerate

   logic ext_sign;
   assign ext_sign = sext && ((fx_size_e'(size) == SZ_HALF) || (fx_size_e'(size) == SZ_WORD));

   always_comb begin
      if (brev)          result = rev_sz[size];
      else if (ext_sign) result = sx_sz[size];
      else               result = nat_sz[size];
   end

endmodule

// File: rtl/fxld_unit.sv
module fxld_unit #(
   parameter int XLEN   = 64,
   parameter int RIDX_W = 5,
   parameter int IMM_W  = 16,
   parameter int DS_W   = 14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [1:0]        req_size,
   input  logic              req_sext,
   input  logic              req_brev,
   input  logic              req_upd,
   input  logic [1:0]        req_mode,
   input  logic [RIDX_W-1:0] req_rt,
   input  logic [RIDX_W-1:0] req_ra,
   input  logic [XLEN-1:0]   req_base,
   input  logic [XLEN-1:0]   req_index,
   input  logic [IMM_W-1:0]  req_imm,
   output logic              mem_req_valid,
   output logic [XLEN-1:0]   mem_req_addr,
   output logic [1:0]        mem_req_size,
   input  logic              mem_rsp_valid,
   input  logic [XLEN-1:0]   mem_rsp_data,
   output logic              done,
   output logic              bad_form,
   output logic              rt_we,
   output logic [RIDX_W-1:0] rt_idx,
   output logic [XLEN-1:0]   rt_data,
   output logic              ra_we,
   output logic [RIDX_W-1:0] ra_idx,
   output logic [XLEN-1:0]   ra_data
);
   import fxld_pkg::*;

   fx_state_e         state_q;
   logic [1:0]        size_q;
   logic              sext_q;
   logic              brev_q;
   logic              upd_q;
   logic              bad_q;
   logic [RIDX_W-1:0] rt_q;
   logic [RIDX_W-1:0] ra_q;
   logic [XLEN-1:0]   ea_q;
   logic [XLEN-1:0]   res_q;

   logic [XLEN-1:0]   ea_new;
   logic [XLEN-1:0]   fmt_out;
   logic              take;
   logic              bad_new;

   fxld_agen #(
      .XLEN   (XLEN),
      .RIDX_W (RIDX_W),
      .IMM_W  (IMM_W),
      .DS_W   (DS_W),
      .DS_SHIFT(2)
   ) i_agen (
      .mode  (req_mode),
      .ra    (req_ra),
      .base  (req_base),
      .index (req_index),
      .imm   (req_imm),
      .ea    (ea_new)
   );

   fxld_fmt #(
      .XLEN (XLEN)
   ) i_fmt (
      .size   (size_q),
      .sext   (sext_q),
      .brev   (brev_q),
      .raw    (mem_rsp_data),
      .result (fmt_out)
   );

   assign req_ready = (state_q == ST_IDLE);
   assign take      = req_valid && req_ready;
   assign bad_new   = req_upd && ((req_ra == '0) || (req_ra == req_rt));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         size_q  <= '0;
         sext_q  <= 1'b0;
         brev_q  <= 1'b0;
         upd_q   <= 1'b0;
         bad_q   <= 1'b0;
         rt_q    <= '0;
         ra_q    <= '0;
         ea_q    <= '0;
         res_q   <= '0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (take) begin
                  size_q  <= req_size;
                  sext_q  <= req_sext;
                  brev_q  <= req_brev;
                  upd_q   <= req_upd;
                  bad_q   <= bad_new;
                  rt_q    <= req_rt;
                  ra_q    <= req_ra;
                  ea_q    <= ea_new;
                  res_q   <= '0;
                  state_q <= bad_new ? ST_DONE : ST_ISSUE;
               end
            end
            ST_ISSUE: state_q <= ST_WAIT;
            ST_WAIT: begin
               if (mem_rsp_valid) begin
                  res_q   <= fmt_out;
                  state_q <= ST_DONE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign mem_req_valid = (state_q == ST_ISSUE);
   assign mem_req_addr  = ea_q;
   assign mem_req_size  = size_q;

   assign done     = (state_q == ST_DONE);
   assign bad_form = done && bad_q;
   assign rt_we    = done && !bad_q;
   assign rt_idx   = rt_q;
   assign rt_data  = res_q;
   assign ra_we    = done && !bad_q && upd_q;
   assign ra_idx   = ra_q;
   assign ra_data  = ea_q;

endmodule

// File: rtl/fxld_unit_chk.sv
module fxld_unit_chk #(
   parameter int RIDX_W = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic              req_upd,
   input logic [RIDX_W-1:0] req_rt,
   input logic [RIDX_W-1:0] req_ra,
   input logic              mem_req_valid,
   input logic              done,
   input logic              bad_form,
   input logic              rt_we,
   input logic [RIDX_W-1:0] rt_idx,
   input logic              ra_we,
   input logic [RIDX_W-1:0] ra_idx
);

   a_r1_busy_after_take: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);

   a_r6_single_read: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |=> !mem_req_valid);

   a_r6_read_follows_take: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && !req_upd) |=> mem_req_valid);

   a_r10_update_legal: assert property (@(posedge clk) disable iff (!rst_n)
      ra_we |-> (rt_we && (ra_idx != '0) && (ra_idx != rt_idx)));

   a_r11_reject_no_read: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && req_upd && ((req_ra == '0) || (req_ra == req_rt)))
      |=> (bad_form && !mem_req_valid));

   a_r11_reject_no_wb: assert property (@(posedge clk) disable iff (!rst_n)
      bad_form |-> (done && !rt_we && !ra_we));

   a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

endmodule

bind fxld_unit fxld_unit_chk #(.RIDX_W(RIDX_W)) i_fxld_unit_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .req_valid     (req_valid),
   .req_ready     (req_ready),
   .req_upd       (req_upd),
   .req_rt        (req_rt),
   .req_ra        (req_ra),
   .mem_req_valid (mem_req_valid),
   .done          (done),
   .bad_form      (bad_form),
   .rt_we         (rt_we),
   .rt_idx        (rt_idx),
   .ra_we         (ra_we),
   .ra_idx        (ra_idx)
);

// File: tb/test_fxld_unit.sv
`timescale 1ns/1ps
module test_fxld_unit;

   localparam int NVEC = 13;

   typedef struct packed {
      logic [1:0]  size;
      logic        sext;
      logic        brev;
      logic        upd;
      logic [1:0]  mode;
      logic [4:0]  rt;
      logic [4:0]  ra;
      logic [63:0] base;
      logic [63:0] idx;
      logic [15:0] imm;
      logic [63:0] exp_ea;
   } vec_t;

   localparam vec_t VEC [NVEC] = '{
      '{2'd0, 1'b0, 1'b0, 1'b0, 2'd0, 5'd4, 5'd3, 64'h1000, 64'h0, 16'h0010, 64'h1010},
      '{2'd1, 1'b1, 1'b0, 1'b0, 2'd0, 5'd4, 5'd3, 64'h2000, 64'h0, 16'hFFF0, 64'h1FF0},
      '{2'd2, 1'b1, 1'b0, 1'b0, 2'd1, 5'd9, 5'd1, 64'h3000, 64'h0, 16'h3FFF, 64'h2FFC},
      '{2'd3, 1'b0, 1'b0, 1'b0, 2'd1, 5'd9, 5'd1, 64'h4000, 64'h0, 16'h0002, 64'h4008},
      '{2'd3, 1'b1, 1'b0, 1'b0, 2'd1, 5'd9, 5'd1, 64'h5000, 64'h0, 16'hC001, 64'h5004},
      '{2'd2, 1'b0, 1'b0, 1'b0, 2'd2, 5'd7, 5'd0, 64'hDEAD, 64'h500, 16'h0000, 64'h0500},
      '{2'd1, 1'b1, 1'b1, 1'b0, 2'd2, 5'd7, 5'd2, 64'h600, 64'h7, 16'h0000, 64'h0607},
      '{2'd2, 1'b0, 1'b1, 1'b0, 2'd3, 5'd7, 5'd2, 64'h700, 64'h10, 16'h0000, 64'h0710},
      '{2'd3, 1'b0, 1'b1, 1'b0, 2'd2, 5'd7, 5'd2, 64'h800, 64'h8, 16'h0000, 64'h0808},
      '{2'd1, 1'b0, 1'b0, 1'b1, 2'd0, 5'd6, 5'd5, 64'h900, 64'h0, 16'h0020, 64'h0920},
      '{2'd2, 1'b1, 1'b0, 1'b1, 2'd2, 5'd8, 5'd7, 64'hA00, 64'h40, 16'h0000, 64'h0A40},
      '{2'd2, 1'b0, 1'b0, 1'b0, 2'd0, 5'd2, 5'd0, 64'hFFFF0000, 64'h0, 16'h7FFC, 64'h7FFC},
      '{2'd0, 1'b1, 1'b0, 1'b0, 2'd0, 5'd2, 5'd1, 64'h10F0, 64'h0, 16'h000F, 64'h10FF}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [1:0]  req_size = '0;
   logic        req_sext = 1'b0;
   logic        req_brev = 1'b0;
   logic        req_upd = 1'b0;
   logic [1:0]  req_mode = '0;
   logic [4:0]  req_rt = '0;
   logic [4:0]  req_ra = '0;
   logic [63:0] req_base = '0;
   logic [63:0] req_index = '0;
   logic [15:0] req_imm = '0;
   logic        mem_req_valid;
   logic [63:0] mem_req_addr;
   logic [1:0]  mem_req_size;
   logic        mem_rsp_valid = 1'b0;
   logic [63:0] mem_rsp_data = '0;
   logic        done;
   logic        bad_form;
   logic        rt_we;
   logic [4:0]  rt_idx;
   logic [63:0] rt_data;
   logic        ra_we;
   logic [4:0]  ra_idx;
   logic [63:0] ra_data;

   int checks = 0;
   int errors = 0;
   int mem_cnt = 0;
   int cycles = 0;
   logic [63:0] last_addr = '0;
   logic [1:0]  last_size = '0;

   always #2 clk = ~clk;

   fxld_unit i_fxld_unit (
      .clk, .rst_n, .req_valid, .req_ready, .req_size, .req_sext, .req_brev,
      .req_upd, .req_mode, .req_rt, .req_ra, .req_base, .req_index, .req_imm,
      .mem_req_valid, .mem_req_addr, .mem_req_size, .mem_rsp_valid, .mem_rsp_data,
      .done, .bad_form, .rt_we, .rt_idx, .rt_data, .ra_we, .ra_idx, .ra_data
   );

   function automatic logic [7:0] mem_byte(input logic [63:0] a);
      return 8'(a[7:0] * 8'd37 + 8'd11);
   endfunction

   function automatic logic [63:0] mem_value(input logic [63:0] a, input logic [1:0] sz);
      logic [63:0] v = '0;
      for (int i = 0; i < (1 << sz); i++) v = (v << 8) | 64'(mem_byte(a + 64'(i)));
      return v;
   endfunction

   function automatic logic [63:0] exp_load(input logic [63:0] a, input logic [1:0] sz,
                                            input logic sx, input logic br);
      logic [63:0] v;
      int w;
      w = 8 << sz;
      if (br) begin
         v = '0;
         for (int i = 0; i < (1 << sz); i++) v = v | (64'(mem_byte(a + 64'(i))) << (8 * i));
      end else begin
         v = mem_value(a, sz);
         if (sx && (sz == 2'd1 || sz == 2'd2) && v[w-1]) v = v | ~((64'd1 << w) - 64'd1);
      end
      return v;
   endfunction

   // memory model: answers one cycle after each read request
   always @(posedge clk) begin
      cycles <= cycles + 1;
      mem_rsp_valid <= 1'b0;
      if (mem_req_valid) begin
         mem_rsp_valid <= 1'b1;
         mem_rsp_data  <= mem_value(mem_req_addr, mem_req_size);
         last_addr     <= mem_req_addr;
         last_size     <= mem_req_size;
         mem_cnt       <= mem_cnt + 1;
      end
   end

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   always @(negedge clk) begin
      if (cycles > 100000) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
         finish_run();
      end
   end

   logic        c_done, c_bad, c_rtwe, c_rawe, c_after;
   logic [4:0]  c_rtidx, c_raidx;
   logic [63:0] c_rtdata, c_radata;
   int          c_reads;

   task automatic run_op(input vec_t v, input bit poke);
      int n0;
      @(negedge clk);
      req_size = v.size; req_sext = v.sext; req_brev = v.brev; req_upd = v.upd;
      req_mode = v.mode; req_rt = v.rt; req_ra = v.ra; req_base = v.base;
      req_index = v.idx; req_imm = v.imm; req_valid = 1'b1;
      n0 = mem_cnt;
      @(negedge clk);
      if (poke) begin
         req_rt = 5'd30; req_ra = 5'd29; req_base = 64'hF000; req_upd = 1'b0;
      end else begin
         req_valid = 1'b0;
      end
      for (int k = 0; k < 40 && !done; k++) @(negedge clk);
      req_valid = 1'b0;
      c_done = done; c_bad = bad_form; c_rtwe = rt_we; c_rawe = ra_we;
      c_rtidx = rt_idx; c_raidx = ra_idx; c_rtdata = rt_data; c_radata = ra_data;
      @(negedge clk);
      c_after = done;
      c_reads = mem_cnt - n0;
   endtask

   initial begin
      vec_t d;
      repeat (3) @(negedge clk);
      // R13: reset state
      chk(req_ready === 1'b1 && done === 1'b0 && mem_req_valid === 1'b0 &&
          rt_we === 1'b0 && ra_we === 1'b0 && bad_form === 1'b0, "R13 reset outputs",
          {58'b0, req_ready, done, mem_req_valid, rt_we, ra_we, bad_form}, 64'h20);
      rst_n = 1'b1;

      for (int i = 0; i < NVEC; i++) begin
         string atag, dtag;
         run_op(VEC[i], 1'b0);
         atag = (VEC[i].ra == 5'd0) ? "R5 zero base" :
                (VEC[i].mode == 2'd0) ? "R2 displacement EA" :
                (VEC[i].mode == 2'd1) ? "R3 scaled EA" : "R4 indexed EA";
         dtag = VEC[i].brev ? "R9 reversed data" :
                VEC[i].sext ? "R8 sign-extended data" : "R7 zero-extended data";
         chk(c_done === 1'b1 && c_rtwe === 1'b1 && c_rtidx === VEC[i].rt, "R12 done with rt write",
             {58'b0, c_done, c_rtwe, 4'b0}, 64'h30);
         chk(last_addr === VEC[i].exp_ea, atag, last_addr, VEC[i].exp_ea);
         chk(c_reads == 1 && last_size === VEC[i].size, "R6 one read with size",
             64'(c_reads * 16 + last_size), 64'(16 + VEC[i].size));
         chk(c_rtdata === exp_load(VEC[i].exp_ea, VEC[i].size, VEC[i].sext, VEC[i].brev),
             dtag, c_rtdata, exp_load(VEC[i].exp_ea, VEC[i].size, VEC[i].sext, VEC[i].brev));
         if (VEC[i].upd)
            chk(c_rawe === 1'b1 && c_raidx === VEC[i].ra && c_radata === VEC[i].exp_ea,
                "R10 base update", c_radata, VEC[i].exp_ea);
         else
            chk(c_rawe === 1'b0, "R12 no base write without update", 64'(c_rawe), 64'h0);
         chk(c_after === 1'b0, "R12 done one cycle", 64'(c_after), 64'h0);
      end

      // R11: update with base register 0
      d = '{2'd2, 1'b0, 1'b0, 1'b1, 2'd0, 5'd4, 5'd0, 64'h100, 64'h0, 16'h4, 64'h104};
      run_op(d, 1'b0);
      chk(c_bad === 1'b1 && c_rtwe === 1'b0 && c_rawe === 1'b0 && c_reads == 0,
          "R11 update with zero base rejected", {60'b0, c_bad, c_rtwe, c_rawe, 1'b0} | 64'(c_reads), 64'h8);

      // R11: update with base equal to destination
      d = '{2'd3, 1'b0, 1'b0, 1'b1, 2'd2, 5'd6, 5'd6, 64'h100, 64'h8, 16'h0, 64'h108};
      run_op(d, 1'b0);
      chk(c_bad === 1'b1 && c_rtwe === 1'b0 && c_rawe === 1'b0 && c_reads == 0,
          "R11 update with base equal to target rejected", {60'b0, c_bad, c_rtwe, c_rawe, 1'b0} | 64'(c_reads), 64'h8);

      // R1: requests offered while busy are ignored
      d = '{2'd1, 1'b0, 1'b0, 1'b0, 2'd0, 5'd11, 5'd12, 64'h2200, 64'h0, 16'h0002, 64'h2202};
      run_op(d, 1'b1);
      chk(c_reads == 1 && c_rtidx === 5'd11 && last_addr === 64'h2202 &&
          c_rtdata === exp_load(64'h2202, 2'd1, 1'b0, 1'b0),
          "R1 busy offer ignored", last_addr, 64'h2202);
      @(negedge clk);
      chk(req_ready === 1'b1 && done === 1'b0, "R1 idle after op", 64'(req_ready), 64'h1);

      finish_run();
   end

endmodule